// File: doc/BRIEF.md
# Parallel Synchronous Transmit Port

This block sends words from a small internal queue onto a 16-bit parallel bus that a receiving device samples with an external data clock. Local logic writes words into the queue through a simple write strobe. The port watches the external data clock and, on each launch edge, puts the next queued word on the bus. A data-enable output marks a launched word as valid. A ready input lets the receiver hold the stream back. Ready is an input because it travels in the opposite direction to the data.

The external clock is oversampled in the local clock domain through a short synchroniser, so every launch is a local-clock event. Each level of the external clock must therefore last at least four local clock cycles. The clock polarity setting picks the launch edge, and the receiver samples on the other edge. When the queue is empty at a launch edge, the bus keeps its last word and data-enable drops. When the receiver is not ready at a launch edge, the bus and data-enable stay as they are and the queue is not touched. The word width can be 16 bits or 8 bits. In 8-bit mode only the lower lanes carry data.

Top module: `par_sync_tx`

## Requirements
- R1: With clk_pol = 0 a falling edge of pdck is a launch edge; with clk_pol = 1 a rising edge is. The bus and de_out settle within three local clock cycles of a launch edge and are stable at the following opposite (sampling) edge.
- R2: Words leave in the order they were written. At a launch edge where the queue holds a word and ready is active, the oldest word is removed, driven on pd_out, and de_out is raised (when enabled).
- R3: At a launch edge with the queue empty, pd_out keeps its previous value and de_out goes low.
- R4: At a launch edge with ready inactive, no word is removed, and pd_out and de_out keep their values.
- R5: Ready is active low when rdy_pol = 0 and active high when rdy_pol = 1.
- R6: When rdy_en = 0 the level on rdy_in has no effect, and ready counts as active.
- R7: When de_en = 0, de_out stays low while words are still launched and the queue still drains.
- R8: width_mode = 2'b11 selects 16-bit words. Any other code selects 8-bit words: pd_out[7:0] = wr_data[7:0] of the word and pd_out[15:8] = 0.
- R9: While port_en = 0, de_out is low from the next local clock cycle, no word is removed, and pd_out is unchanged.
- R10: The queue holds 8 words. fifo_full is high after 8 unread writes. fifo_empty is high when nothing is queued. The two are never high together.
- R11: A write while full is dropped and sets fifo_overflow, which stays set until reset. A write in the same cycle as a removal is accepted, even when the queue is full.
- R12: After reset, fifo_empty = 1, fifo_full = 0, fifo_overflow = 0, de_out = 0 and pd_out = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en | input | 1 | Enables launching from the queue |
| width_mode | input | 2 | 2'b11 selects 16-bit words; any other code selects 8-bit |
| clk_pol | input | 1 | 0: launch on falling pdck edge; 1: launch on rising edge |
| de_en | input | 1 | Enables the data-enable output |
| rdy_en | input | 1 | Enables the ready input |
| rdy_pol | input | 1 | Active level of rdy_in |
| wr_en | input | 1 | Write strobe into the queue |
| wr_data | input | 16 | Word to queue |
| fifo_full | output | 1 | Queue holds 8 words |
| fifo_empty | output | 1 | Queue holds no word |
| fifo_overflow | output | 1 | Sticky flag: a write was dropped |
| pdck | input | 1 | External data clock |
| rdy_in | input | 1 | Ready from the receiver |
| pd_out | output | 16 | Parallel data bus |
| de_out | output | 1 | Data valid, active high |

## Verification
A removal at a launch edge and a write from local logic can land in the same local clock cycle. This matters most when the queue is full, because only then does it decide whether the write is kept. The bench fills the queue with the port disabled, then enables it and holds the write strobe high with one constant word across a whole launch window. Exactly one copy of that word must reach the bus, after the eight earlier words and in order. fifo_overflow must then be set by the strobes that were turned away.

// File: rtl/ptx_pkg.sv
package ptx_pkg;

    localparam logic [1:0] WMODE_WIDE = 2'b11;

    typedef struct packed {
        logic       port_en;
        logic [1:0] wmode;
        logic       clk_pol;
        logic       de_en;
        logic       rdy_en;
        logic       rdy_pol;
    } ptx_cfg_t;

    function automatic logic is_narrow(input logic [1:0] mode);
        return mode != WMODE_WIDE;
    endfunction

endpackage

// File: rtl/ptx_sync.sv
module ptx_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] pipe;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.pipe[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            st_d.pipe[i] = st_q.pipe[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.pipe[STAGES-1];

endmodule

// File: rtl/ptx_fifo.sv
module ptx_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         full,
    output logic         empty,
    output logic         overflow
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        wr_ptr;
        logic [PTR_W-1:0]        rd_ptr;
        logic [CNT_W-1:0]        count;
        logic                    ovf;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     accept;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full   = (st_q.count == CNT_W'(DEPTH));
    assign empty  = (st_q.count == '0);
    assign accept = wr_en && (!full || pop);

    always_comb begin
        st_d = st_q;
        if (accept) begin
            st_d.mem[st_q.wr_ptr] = wr_data;
            st_d.wr_ptr           = ptr_next(st_q.wr_ptr);
        end
        if (pop) begin
            st_d.rd_ptr = ptr_next(st_q.rd_ptr);
        end
        case ({accept, pop})
            2'b10:   st_d.count = st_q.count + 1'b1;
            2'b01:   st_d.count = st_q.count - 1'b1;
            default: st_d.count = st_q.count;
        endcase
        if (wr_en && !accept) begin
            st_d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head     = st_q.mem[st_q.rd_ptr];
    assign overflow = st_q.ovf;

endmodule

// File: rtl/ptx_launch.sv
module ptx_launch
    import ptx_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ptx_cfg_t          cfg,
    input  logic              pdck_s,
    input  logic              rdy_s,
    input  logic              fifo_empty,
    input  logic [DATA_W-1:0] fifo_head,
    output logic              pop,
    output logic              launch,
    output logic              rdy_act,
    output logic [DATA_W-1:0] pd_out,
    output logic              de_out
);

    localparam int HALF_W = DATA_W / 2;

    typedef struct packed {
        logic              pdck_prev;
        logic              de;
        logic [DATA_W-1:0] data;
    } launch_st_t;

    launch_st_t        st_d, st_q;
    logic [DATA_W-1:0] shaped;

    always_comb begin
        launch  = (pdck_s != st_q.pdck_prev) && (pdck_s == cfg.clk_pol);
        rdy_act = !cfg.rdy_en || (rdy_s == cfg.rdy_pol);
        pop     = cfg.port_en && launch && !fifo_empty && rdy_act;
        shaped  = is_narrow(cfg.wmode)
                ? {{(DATA_W - HALF_W){1'b0}}, fifo_head[HALF_W-1:0]}
                : fifo_head;

        st_d           = st_q;
        st_d.pdck_prev = pdck_s;
        if (!cfg.port_en) begin
            st_d.de = 1'b0;
        end else if (launch) begin
            if (fifo_empty) begin
                st_d.de = 1'b0;
            end else if (rdy_act) begin
                st_d.de   = 1'b1;
                st_d.data = shaped;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pd_out = st_q.data;
    assign de_out = st_q.de && cfg.de_en;

endmodule

// File: rtl/par_sync_tx.sv
module par_sync_tx
    import ptx_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int DEPTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              port_en,
    input  logic [1:0]        width_mode,
    input  logic              clk_pol,
    input  logic              de_en,
    input  logic              rdy_en,
    input  logic              rdy_pol,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              fifo_full,
    output logic              fifo_empty,
    output logic              fifo_overflow,
    input  logic              pdck,
    input  logic              rdy_in,
    output logic [DATA_W-1:0] pd_out,
    output logic              de_out
);

    ptx_cfg_t          cfg;
    logic [1:0]        pins_s;
    logic              pop_w;
    logic              launch_w;
    logic              rdy_act_w;
    logic [DATA_W-1:0] head_w;

    always_comb begin
        cfg.port_en = port_en;
        cfg.wmode   = width_mode;
        cfg.clk_pol = clk_pol;
        cfg.de_en   = de_en;
        cfg.rdy_en  = rdy_en;
        cfg.rdy_pol = rdy_pol;
    end

    ptx_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({rdy_in, pdck}),
        .dout  (pins_s)
    );

    ptx_fifo #(
        .W     (DATA_W),
        .DEPTH (DEPTH)
    ) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .pop      (pop_w),
        .head     (head_w),
        .full     (fifo_full),
        .empty    (fifo_empty),
        .overflow (fifo_overflow)
    );

    ptx_launch #(
        .DATA_W (DATA_W)
    ) u_launch (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg        (cfg),
        .pdck_s     (pins_s[0]),
        .rdy_s      (pins_s[1]),
        .fifo_empty (fifo_empty),
        .fifo_head  (head_w),
        .pop        (pop_w),
        .launch     (launch_w),
        .rdy_act    (rdy_act_w),
        .pd_out     (pd_out),
        .de_out     (de_out)
    );

endmodule

// File: rtl/par_sync_tx_chk.sv
module par_sync_tx_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              port_en,
    input logic [1:0]        width_mode,
    input logic              fifo_full,
    input logic              fifo_empty,
    input logic              fifo_overflow,
    input logic [DATA_W-1:0] pd_out,
    input logic              de_out,
    input logic              launch,
    input logic              rdy_act,
    input logic              pop
);

    localparam int HALF_W = DATA_W / 2;

    // R3
    empty_launch_de_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && fifo_empty && port_en) |=> !de_out);

    // R3
    empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_empty |=> $stable(pd_out));

    // R4
    not_ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && !rdy_act) |=> $stable(pd_out));

    // R8
    narrow_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && width_mode != 2'b11) |=> (pd_out[DATA_W-1:HALF_W] == '0));

    // R9
    disabled_de_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en |=> !de_out);

    // R10
    full_empty_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_full && fifo_empty));

    // R11
    overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_overflow |=> fifo_overflow);

endmodule

bind par_sync_tx par_sync_tx_chk #(.DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .port_en       (port_en),
    .width_mode    (width_mode),
    .fifo_full     (fifo_full),
    .fifo_empty    (fifo_empty),
    .fifo_overflow (fifo_overflow),
    .pd_out        (pd_out),
    .de_out        (de_out),
    .launch        (launch_w),
    .rdy_act       (rdy_act_w),
    .pop           (pop_w)
);

// File: tb/tb_par_sync_tx.sv
module tb_par_sync_tx;

    localparam int HALF = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        port_en = 1'b0;
    logic [1:0]  width_mode = 2'b11;
    logic        clk_pol = 1'b0;
    logic        de_en = 1'b1;
    logic        rdy_en = 1'b1;
    logic        rdy_pol = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        pdck = 1'b0;
    logic        rdy_in = 1'b1;
    logic        fifo_full, fifo_empty, fifo_overflow, de_out;
    logic [15:0] pd_out;

    logic        rdy_want = 1'b1;
    logic [15:0] expq[$];
    int          n_chk = 0;
    int          n_fail = 0;

    always #10 clk = ~clk;

    par_sync_tx dut (
        .clk(clk), .rst_n(rst_n), .port_en(port_en), .width_mode(width_mode),
        .clk_pol(clk_pol), .de_en(de_en), .rdy_en(rdy_en), .rdy_pol(rdy_pol),
        .wr_en(wr_en), .wr_data(wr_data), .fifo_full(fifo_full),
        .fifo_empty(fifo_empty), .fifo_overflow(fifo_overflow), .pdck(pdck),
        .rdy_in(rdy_in), .pd_out(pd_out), .de_out(de_out)
    );

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic rdy_level();
        return rdy_en ? (rdy_want ? rdy_pol : ~rdy_pol) : ~rdy_pol;
    endfunction

    task automatic wait_launch();
        do @(pdck); while (pdck !== clk_pol);
    endtask

    task automatic idle_wait(input int n);
        for (int i = 0; i < n; i++) wait_launch();
        repeat (4) @(negedge clk);
    endtask

    task automatic push_word(input logic [15:0] d, input bit track);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (track) expq.push_back((width_mode != 2'b11) ? {8'h00, d[7:0]} : d);
    endtask

    // external data clock
    initial begin
        forever begin
            repeat (HALF) @(negedge clk);
            pdck = ~pdck;
        end
    end

    // receiver ready, updated mid-way between a launch and the next sampling edge
    initial begin
        forever begin
            wait_launch();
            repeat (4) @(negedge clk);
            rdy_in = rdy_level();
        end
    end

    // scoreboard monitor at receiver sampling edges
    initial begin
        forever begin
            @(pdck);
            if (rst_n && pdck !== clk_pol && de_out && (!rdy_en || rdy_in == rdy_pol)) begin
                if (expq.size() == 0) begin
                    chk(1'b0, "R2 unexpected word", pd_out, 16'h0000);
                end else begin
                    logic [15:0] e;
                    e = expq.pop_front();
                    chk(pd_out === e, "R1 R2 word at sampling edge", pd_out, e);
                end
            end
        end
    end

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%h expected=%h", 16'h0, 16'h1);
        summary();
        $finish;
    end

    initial begin
        logic [15:0] held;
        repeat (3) @(negedge clk);
        // R12 reset state
        chk(fifo_empty === 1'b1, "R12 empty", {15'h0, fifo_empty}, 16'h1);
        chk(fifo_full === 1'b0, "R12 full", {15'h0, fifo_full}, 16'h0);
        chk(fifo_overflow === 1'b0, "R12 overflow", {15'h0, fifo_overflow}, 16'h0);
        chk(de_out === 1'b0, "R12 de", {15'h0, de_out}, 16'h0);
        chk(pd_out === 16'h0, "R12 data", pd_out, 16'h0);
        rst_n = 1'b1;

        // R2 R3: 16-bit stream, falling-edge launch
        idle_wait(1);
        port_en = 1'b1;
        push_word(16'hA1B2, 1'b1);
        push_word(16'hC3D4, 1'b1);
        push_word(16'hE5F6, 1'b1);
        idle_wait(6);
        chk(expq.size() == 0, "R2 all words delivered", 16'(expq.size()), 16'h0);
        chk(de_out === 1'b0, "R3 de low on empty", {15'h0, de_out}, 16'h0);
        chk(pd_out === 16'hE5F6, "R3 last word held", pd_out, 16'hE5F6);
        chk(fifo_empty === 1'b1, "R3 queue drained", {15'h0, fifo_empty}, 16'h1);

        // R8 narrow modes
        width_mode = 2'b00;
        push_word(16'hA55A, 1'b1);
        push_word(16'h3C81, 1'b1);
        width_mode = 2'b01;
        push_word(16'hFF11, 1'b1);
        idle_wait(6);
        chk(expq.size() == 0, "R8 narrow words delivered", 16'(expq.size()), 16'h0);
        chk(pd_out === 16'h0011, "R8 upper lanes zero", pd_out, 16'h0011);
        width_mode = 2'b11;

        // R6 ready ignored when disabled
        rdy_en = 1'b0;
        rdy_in = rdy_level();
        push_word(16'h1357, 1'b1);
        push_word(16'h2468, 1'b1);
        idle_wait(5);
        chk(expq.size() == 0, "R6 ready disabled still flows", 16'(expq.size()), 16'h0);
        chk(pd_out === 16'h2468, "R6 last word", pd_out, 16'h2468);
        rdy_en = 1'b1;
        rdy_in = rdy_level();

        // R5 active-low ready
        rdy_pol = 1'b0;
        rdy_in  = rdy_level();
        push_word(16'h0F0F, 1'b1);
        idle_wait(4);
        chk(expq.size() == 0, "R5 active-low ready accepted", 16'(expq.size()), 16'h0);
        rdy_want = 1'b0;
        idle_wait(2);
        chk(rdy_in === 1'b1, "R5 inactive level is high", {15'h0, rdy_in}, 16'h1);
        push_word(16'h7001, 1'b1);
        push_word(16'h7002, 1'b1);
        idle_wait(4);
        chk(fifo_empty === 1'b0, "R5 R4 no removal while not ready", {15'h0, fifo_empty}, 16'h0);
        chk(pd_out === 16'h0F0F, "R4 bus unchanged while not ready", pd_out, 16'h0F0F);
        rdy_want = 1'b1;
        idle_wait(6);
        chk(expq.size() == 0, "R5 resumed after ready", 16'(expq.size()), 16'h0);
        rdy_pol = 1'b1;
        rdy_in  = rdy_level();
        idle_wait(1);

        // R4 stall in mid-stream
        for (int k = 0; k < 5; k++) push_word(16'h4000 + 16'(k), 1'b1);
        wait_launch();
        wait_launch();
        rdy_want = 1'b0;
        idle_wait(2);
        held = pd_out;
        chk(de_out === 1'b1, "R4 de held high in stall", {15'h0, de_out}, 16'h1);
        idle_wait(2);
        chk(pd_out === held, "R4 data held in stall", pd_out, held);
        chk(de_out === 1'b1, "R4 de still high", {15'h0, de_out}, 16'h1);
        rdy_want = 1'b1;
        idle_wait(8);
        chk(expq.size() == 0, "R4 no word lost or repeated", 16'(expq.size()), 16'h0);

        // R7 data-enable disabled
        de_en = 1'b0;
        push_word(16'h5A01, 1'b0);
        push_word(16'h5A02, 1'b0);
        for (int k = 0; k < 4; k++) begin
            idle_wait(1);
            chk(de_out === 1'b0, "R7 de stays low", {15'h0, de_out}, 16'h0);
        end
        chk(fifo_empty === 1'b1, "R7 queue still drains", {15'h0, fifo_empty}, 16'h1);
        chk(pd_out === 16'h5A02, "R7 words still launched", pd_out, 16'h5A02);
        de_en = 1'b1;

        // R1 rising-edge launch
        clk_pol = 1'b1;
        idle_wait(2);
        push_word(16'h9876, 1'b1);
        repeat (2) @(negedge clk);
        wait_launch();
        chk(pdck === 1'b1, "R1 launch on rising edge", {15'h0, pdck}, 16'h1);
        chk(pd_out === 16'h5A02, "R1 no change before sync", pd_out, 16'h5A02);
        repeat (4) @(negedge clk);
        chk(pd_out === 16'h9876, "R1 word launched on rising edge", pd_out, 16'h9876);
        chk(de_out === 1'b1, "R1 de with word", {15'h0, de_out}, 16'h1);
        idle_wait(3);
        chk(expq.size() == 0, "R1 word sampled on falling edge", 16'(expq.size()), 16'h0);

        // R9 port disabled
        port_en = 1'b0;
        push_word(16'h6601, 1'b1);
        push_word(16'h6602, 1'b1);
        idle_wait(4);
        chk(fifo_empty === 1'b0, "R9 no removal while disabled", {15'h0, fifo_empty}, 16'h0);
        chk(de_out === 1'b0, "R9 de low while disabled", {15'h0, de_out}, 16'h0);
        chk(pd_out === 16'h9876, "R9 bus unchanged while disabled", pd_out, 16'h9876);
        port_en = 1'b1;
        idle_wait(6);
        chk(expq.size() == 0, "R9 resumed after enable", 16'(expq.size()), 16'h0);

        // R10 R11 fill, overflow, and write in the cycle of a removal
        port_en = 1'b0;
        for (int k = 0; k < 8; k++) push_word(16'h8100 + 16'(k), 1'b1);
        chk(fifo_full === 1'b1, "R10 full after 8 writes", {15'h0, fifo_full}, 16'h1);
        chk(fifo_overflow === 1'b0, "R11 no overflow yet", {15'h0, fifo_overflow}, 16'h0);
        push_word(16'hDEAD, 1'b0);
        chk(fifo_overflow === 1'b1, "R11 overflow on dropped write", {15'h0, fifo_overflow}, 16'h1);
        chk(fifo_full === 1'b1, "R10 still full", {15'h0, fifo_full}, 16'h1);
        wait_launch();
        repeat (4) @(negedge clk);
        port_en = 1'b1;
        repeat (10) @(negedge clk);
        wr_en   = 1'b1;
        wr_data = 16'hBEEF;
        repeat (10) @(negedge clk);
        wr_en = 1'b0;
        expq.push_back(16'hBEEF);
        idle_wait(12);
        chk(expq.size() == 0, "R11 one concurrent write kept", 16'(expq.size()), 16'h0);
        chk(pd_out === 16'hBEEF, "R11 concurrent word last", pd_out, 16'hBEEF);
        chk(fifo_empty === 1'b1, "R10 empty after drain", {15'h0, fifo_empty}, 16'h1);
        chk(fifo_overflow === 1'b1, "R11 overflow sticky", {15'h0, fifo_overflow}, 16'h1);

        summary();
        $finish;
    end

endmodule